// File: doc/BRIEF.md
# Two-Level Shared Interrupt Aggregator

This block gathers single-cycle event pulses from a removable-card controller into a sticky per-source status register. A separate per-source enable mask selects which latched events count toward a request. The enabled and pending sources feed bit 0 of a global status register. Bit 1 of that register belongs to a second peripheral, which raises it with a pulse of its own. The global level has two masks. A status-enable mask controls whether a request may latch into the global status at all. A signal-enable mask controls whether a latched global bit drives the single registered interrupt line to the CPU.

Both status registers are write-one-to-clear, and an incoming set always beats a clear in the same cycle. Software runs the usual sequence: it reads the global status, then reads and clears the per-source status, then clears the global bit. All registers sit on a simple 32-bit register bus. Writes take effect on the clock edge, and reads are combinational from the registered state.

Top module: `cascade_irq_hub`

## Requirements
- R1: After reset every register (word addresses 0 to 4) reads 0 and `irq_o` is 0.
- R2: A pulse on `src_evt[i]` sets source status bit i (word 0) at the next edge, whatever the enable state. The implemented bits are 0, 1, 2, 3, 8, 9, 10 and 11. Bits 4 to 7 never set and always read 0.
- R3: Writing word 0 clears each source status bit whose data bit is 1 and leaves bits written 0 unchanged.
- R4: If a source event and a clearing write to the same bit land in one cycle, the bit ends up set.
- R5: The source enable register (word 1) stores written data on its implemented bits (mask 0xF0F) and reads 0 on the other bits.
- R6: Global status bit 0 (word 2) sets one edge after any source has both its status and its enable bit at 1, but only while global status-enable bit 0 (word 3) is 1. Otherwise it stays 0.
- R7: A pulse on `peer_evt` sets global status bit 1 at the next edge when global status-enable bit 1 is 1, and has no effect when that bit is 0.
- R8: Writing ones to word 2 clears those global bits. A simultaneous set wins. Bit 0 re-latches at once while an enabled source is still pending.
- R9: `irq_o` is registered. It equals, one edge later, the OR over bits of global status AND signal-enable (word 4). A global bit whose signal-enable is 0 never drives the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_evt | input | 12 | Per-source event pulses from the card controller |
| peer_evt | input | 1 | Event pulse from the second peripheral |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
Two operations can fall in the same cycle: an event setting a status bit and a software write clearing that same bit. This can happen at both levels. The bench provokes it by driving the event pulse and the write-one-to-clear strobe in one cycle. It does this once at the source level and once at the global level with the peer pulse, then reads the bit back and expects it to be 1. A related case is clearing global bit 0 while its enabled source is still pending. The bench expects that bit to read 1 again immediately.

// File: rtl/cascade_irq_hub.sv
module cascade_irq_hub #(
  parameter int              DW       = 32,
  parameter int              SRC_W    = 12,
  parameter logic [SRC_W-1:0] SRC_IMPL = 12'hF0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [SRC_W-1:0] src_evt,
  input  logic          peer_evt,
  output logic          irq_o
);
  localparam int GW = 2;
  localparam logic [2:0] A_SSTAT = 3'd0;
  localparam logic [2:0] A_SEN   = 3'd1;
  localparam logic [2:0] A_GSTAT = 3'd2;
  localparam logic [2:0] A_GSTEN = 3'd3;
  localparam logic [2:0] A_GSGEN = 3'd4;

  logic [SRC_W-1:0] src_stat, src_en, src_clr;
  logic [GW-1:0]    glb_stat, glb_sten, glb_sgen, glb_clr, glb_set;
  logic             card_pend;
  logic             unused_wd;

  assign unused_wd = &{1'b0, bus_wdata[DW-1:SRC_W]};

  assign src_clr   = (bus_we && bus_addr == A_SSTAT) ? bus_wdata[SRC_W-1:0] : '0;
  assign glb_clr   = (bus_we && bus_addr == A_GSTAT) ? bus_wdata[GW-1:0] : '0;
  assign card_pend = |(src_stat & src_en);
  assign glb_set   = {peer_evt & glb_sten[1], card_pend & glb_sten[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_stat <= '0;
      src_en   <= '0;
      glb_stat <= '0;
      glb_sten <= '0;
      glb_sgen <= '0;
      irq_o    <= 1'b0;
    end else begin
      src_stat <= ((src_stat & ~src_clr) | src_evt) & SRC_IMPL;
      glb_stat <= (glb_stat & ~glb_clr) | glb_set;
      irq_o    <= |(glb_stat & glb_sgen);
      if (bus_we && bus_addr == A_SEN)   src_en   <= bus_wdata[SRC_W-1:0] & SRC_IMPL;
      if (bus_we && bus_addr == A_GSTEN) glb_sten <= bus_wdata[GW-1:0];
      if (bus_we && bus_addr == A_GSGEN) glb_sgen <= bus_wdata[GW-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_SSTAT: bus_rdata = DW'(src_stat);
      A_SEN:   bus_rdata = DW'(src_en);
      A_GSTAT: bus_rdata = DW'(glb_stat);
      A_GSTEN: bus_rdata = DW'(glb_sten);
      A_GSGEN: bus_rdata = DW'(glb_sgen);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module cascade_irq_hub_chk #(
  parameter int              DW       = 32,
  parameter int              SRC_W    = 12,
  parameter logic [SRC_W-1:0] SRC_IMPL = 12'hF0F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [SRC_W-1:0] src_evt,
  input logic             peer_evt,
  input logic [SRC_W-1:0] src_stat,
  input logic [1:0]       glb_stat,
  input logic [1:0]       glb_sten,
  input logic [1:0]       glb_sgen,
  input logic             irq_o
);
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_evt & SRC_IMPL)) |=>
      ((src_stat & $past(src_evt & SRC_IMPL)) == $past(src_evt & SRC_IMPL)));

  a_r2_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_stat & ~SRC_IMPL) == '0);

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && src_evt == '0) |=>
      ((src_stat & $past(bus_wdata[SRC_W-1:0])) == '0));

  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_stat[0] && !glb_sten[0]) |=> !glb_stat[0]);

  a_r7_peer_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_evt && glb_sten[1]) |=> glb_stat[1]);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((glb_stat & glb_sgen) == 2'b00) |=> !irq_o);
endmodule

bind cascade_irq_hub cascade_irq_hub_chk #(.DW(DW), .SRC_W(SRC_W), .SRC_IMPL(SRC_IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .src_evt(src_evt), .peer_evt(peer_evt),
  .src_stat(src_stat), .glb_stat(glb_stat), .glb_sten(glb_sten),
  .glb_sgen(glb_sgen), .irq_o(irq_o)
);

// File: tb/cascade_irq_hub_tb.sv
module cascade_irq_hub_tb;
  localparam logic [11:0] IMPL = 12'hF0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] src_evt = '0;
  logic        peer_evt = 1'b0;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] v;

  cascade_irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .peer_evt(peer_evt), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [11:0] e, input logic p);
    @(negedge clk);
    src_evt = e; peer_evt = p;
    @(negedge clk);
    src_evt = '0; peer_evt = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd0, 32'hFFF);
    wr(3'd2, 32'h3);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    // R5 enable readback
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R5 enable all ones", v, 32'hF0F);
    wr(3'd1, 32'h0000_0A53); rd(3'd1, v); chk("R5 enable pattern", v, 32'h0A03);
    wr(3'd1, 32'h0);

    // R2 / R3 sweep over every source position with enables off
    wr(3'd3, 32'h3); wr(3'd4, 32'h3);
    for (int i = 0; i < 12; i++) begin
      pulse(12'(1 << i), 1'b0);
      rd(3'd0, v);
      chk("R2 event sets bit", v, 32'(IMPL & 12'(1 << i)));
      rd(3'd2, v);
      chk("R6 no global without enable", v, 32'h0);
      chk("R9 irq idle", {31'b0, irq_o}, 32'h0);
      wr(3'd0, 32'(1 << i));
      rd(3'd0, v);
      chk("R3 w1c clears bit", v, 32'h0);
    end

    // R3 partial clear
    pulse(12'hFFF, 1'b0);
    wr(3'd0, 32'h0000_0105);
    rd(3'd0, v); chk("R3 partial clear", v, 32'h0E0A);
    wr(3'd0, 32'hFFF);

    // R4 set beats clear at source level
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h401; src_evt = 12'h001;
    @(negedge clk);
    bus_we = 1'b0; src_evt = '0;
    rd(3'd0, v); chk("R4 set wins over clear", v, 32'h001);
    wr(3'd0, 32'hFFF);

    // R6 / R9 sweep: each source x source enable x global status enable
    wr(3'd4, 32'h1);
    for (int i = 0; i < 12; i++) begin
      if (IMPL[i]) begin
        for (int c = 0; c < 4; c++) begin
          logic en_b, gs_b, want;
          en_b = c[0]; gs_b = c[1];
          want = en_b & gs_b;
          wr(3'd1, en_b ? 32'(1 << i) : 32'h0);
          wr(3'd3, {31'b0, gs_b});
          pulse(12'(1 << i), 1'b0);
          rd(3'd2, v);
          chk("R6 global bit0 latch", v, {31'b0, want});
          chk("R9 irq one cycle later", {31'b0, irq_o}, 32'h0);
          @(negedge clk);
          chk("R9 irq asserts", {31'b0, irq_o}, {31'b0, want});
          if (want) begin
            wr(3'd2, 32'h1);
            rd(3'd2, v);
            chk("R8 bit0 relatches while pending", v, 32'h1);
          end
          clear_all();
          rd(3'd2, v);
          chk("R8 global clears", v, 32'h0);
          @(negedge clk);
          chk("R9 irq drops", {31'b0, irq_o}, 32'h0);
        end
      end
    end
    wr(3'd1, 32'h0);

    // R7 peer bit and R9 signal gating
    wr(3'd3, 32'h2); wr(3'd4, 32'h1);
    pulse(12'h0, 1'b1);
    rd(3'd2, v); chk("R7 peer sets bit1", v, 32'h2);
    @(negedge clk);
    chk("R9 bit1 masked by signal enable", {31'b0, irq_o}, 32'h0);
    wr(3'd4, 32'h2);
    @(negedge clk);
    chk("R9 irq after signal enable", {31'b0, irq_o}, 32'h1);

    // R8 set beats clear at global level
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h2; peer_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; peer_evt = 1'b0;
    rd(3'd2, v); chk("R8 global set wins", v, 32'h2);
    wr(3'd2, 32'h2);
    rd(3'd2, v); chk("R8 global w1c bit1", v, 32'h0);
    @(negedge clk);
    chk("R9 irq falls", {31'b0, irq_o}, 32'h0);

    // R7 peer ignored when status enable off
    wr(3'd3, 32'h1);
    pulse(12'h0, 1'b1);
    rd(3'd2, v); chk("R7 peer ignored when disabled", v, 32'h0);
    @(negedge clk);
    chk("R7 irq stays low", {31'b0, irq_o}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule